// File: doc/BRIEF.md
# Fractional-N Reference Clock Divider

This block divides a fast reference clock by a programmable, unsigned fixed-point ratio N that has 6 integer bits and 18 fractional bits. Every output period lasts a whole number of reference cycles. An 18-bit phase accumulator takes in the fractional part once per period. When the accumulator overflows, that period is one cycle longer, so the long-run average period tracks N to within one fraction LSB.

Firmware writes N over a byte-wide register port. Writes to the two upper bytes only fill a staging area. A write to the low byte moves all 24 bits into the live divisor in one step. The divider reads the live divisor only when a new output period starts, so firmware can retune the clock while it runs without producing a runt pulse. Ratios below 24 are raised to 24. Ratios of 50 or more become exactly 50, with no fractional dither.

Top module: `fracn_clkdiv`

## Requirements
- R1: While reset is asserted, clk_out is low. Reset sets N to 50.0. The first output period after reset release lasts 50 reference cycles.
- R2: Register addresses are: 2 = bits 23:16 (integer part in bits 7:2 of the byte), 1 = bits 15:8, 0 = bits 7:0. A write to address 0 commits the staged upper bytes together with the written low byte. A write to address 3 has no effect.
- R3: Writing addresses 2 and 1 without writing address 0 leaves the output period unchanged.
- R4: Each output period lasts either int(N) or int(N)+1 reference cycles. It lasts int(N)+1 exactly when the 18-bit accumulator carries out after the fraction is added.
- R5: For N = 0x61A800 (24.4140625), any 128 consecutive periods add up to exactly 3125 reference cycles.
- R6: For an N with a zero fraction, every period lasts exactly int(N) cycles.
- R7: A committed N whose integer part is below 24 behaves as 24.0.
- R8: A committed N whose integer part is 50 or more behaves as exactly 50.0, whatever the fraction.
- R9: A newly committed N first takes effect in the next period that starts after the commit. A period that is already running keeps its length.
- R10: In each period the output is high for floor(period/2) cycles, starting at the period's first cycle, and low for the remaining cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Byte register select |
| wr_data | input | 8 | Byte write data |
| clk_out | output | 1 | Divided clock |

## Verification
A low-byte write updates the live divisor on the same clock edge. That divisor is loaded when the next period starts, so it can take up to one full output period before the change shows at clk_out. The bench therefore waits for two rising edges of clk_out after any commit before it queues expected periods. The monitor samples at falling reference edges. It measures each period from one rising edge of clk_out to the next, so a queued expectation always applies to a whole period under a settled divisor. The one exception is the period that is already running when a commit arrives. It is queued on purpose with the old ratio, to show that a running period keeps its length.

// File: rtl/fracn_clkdiv.sv
module fracn_clkdiv #(
  parameter int INT_W  = 6,
  parameter int FRAC_W = 18,
  parameter int N_MIN  = 24,
  parameter int N_MAX  = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       clk_out
);
  localparam int W     = INT_W + FRAC_W;
  localparam int BYTES = W / 8;
  localparam int PER_W = INT_W + 1;

  logic [W-9:0]        stage;
  logic [W-1:0]        div_q;
  logic [FRAC_W-1:0]   acc;
  logic [PER_W-1:0]    per_q;
  logic [PER_W-1:0]    cnt;
  logic                started;

  logic [INT_W-1:0]    n_int, eff_int;
  logic [FRAC_W-1:0]   n_frac, eff_frac;
  logic                too_lo, too_hi, boundary;
  logic [FRAC_W:0]     sum;
  logic [PER_W-1:0]    per_nxt;

  assign n_int    = div_q[W-1:FRAC_W];
  assign n_frac   = div_q[FRAC_W-1:0];
  assign too_lo   = n_int < INT_W'(N_MIN);
  assign too_hi   = n_int >= INT_W'(N_MAX);
  assign eff_int  = too_lo ? INT_W'(N_MIN) : (too_hi ? INT_W'(N_MAX) : n_int);
  assign eff_frac = (too_lo || too_hi) ? '0 : n_frac;
  assign sum      = {1'b0, acc} + {1'b0, eff_frac};
  assign per_nxt  = {1'b0, eff_int} + PER_W'(sum[FRAC_W]);
  assign boundary = !started || (cnt == per_q - PER_W'(1));
  assign clk_out  = started && (cnt < (per_q >> 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '0;
      div_q <= W'(N_MAX) << FRAC_W;
    end else if (wr_en) begin
      if (wr_addr == 2'd0)
        div_q <= {stage, wr_data};
      for (int k = 1; k < BYTES; k++)
        if (wr_addr == 2'(k))
          stage[(k-1)*8 +: 8] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      acc     <= '0;
      cnt     <= '0;
      per_q   <= PER_W'(N_MAX);
    end else if (boundary) begin
      started <= 1'b1;
      cnt     <= '0;
      per_q   <= per_nxt;
      acc     <= sum[FRAC_W-1:0];
    end else begin
      cnt <= cnt + PER_W'(1);
    end
  end
endmodule

// File: rtl/fracn_clkdiv_chk.sv
module fracn_clkdiv_chk #(
  parameter int INT_W  = 6,
  parameter int FRAC_W = 18,
  parameter int N_MIN  = 24,
  parameter int N_MAX  = 50
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [1:0]                wr_addr,
  input logic [7:0]                wr_data,
  input logic                      clk_out,
  input logic                      started,
  input logic [INT_W:0]            cnt,
  input logic [INT_W:0]            per_q,
  input logic [INT_W+FRAC_W-1:0]   div_q
);
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr != 2'd0 |=> $stable(div_q));                          // R3
  AST_COMMIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 2'd0 |=> div_q[7:0] == $past(wr_data));            // R2
  AST_PER_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> per_q >= (INT_W+1)'(N_MIN) && per_q <= (INT_W+1)'(N_MAX)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> cnt < per_q);                                              // R4
  AST_PER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    started && cnt != per_q - 1'b1 |=> $stable(per_q));                    // R9
  AST_DUTY_START: assert property (@(posedge clk) disable iff (!rst_n)
    started && cnt == '0 |-> clk_out);                                     // R10
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !clk_out);                                                // R1
endmodule

bind fracn_clkdiv fracn_clkdiv_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .N_MIN(N_MIN), .N_MAX(N_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .clk_out(clk_out), .started(started),
  .cnt(cnt), .per_q(per_q), .div_q(div_q)
);

// File: tb/fracn_clkdiv_bench.sv
module fracn_clkdiv_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic       clk_out;

  always #5 clk = ~clk;

  fracn_clkdiv u_fracn_clkdiv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clk_out(clk_out)
  );

  typedef struct {
    int    lo;
    int    hi;
    bit    grp;
    string req;
  } exp_t;

  exp_t  q[$];
  exp_t  cur;
  bit    cur_v = 0;
  int    checks = 0, errors = 0;
  int    per_cnt = 0, hi_cnt = 0, grp_sum = 0, cyc = 0;
  bit    prev = 0, rise_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    cyc++;
    rise_seen = 0;
    if (rst_n) begin
      if (clk_out && !prev) begin
        rise_seen = 1;
        if (cur_v) begin
          chk(per_cnt >= cur.lo && per_cnt <= cur.hi, cur.req, per_cnt, cur.lo);
          chk(hi_cnt == per_cnt / 2, "R10", hi_cnt, per_cnt / 2);
          if (cur.grp) grp_sum += per_cnt;
        end
        if (q.size() > 0) begin cur = q.pop_front(); cur_v = 1; end
        else cur_v = 0;
        per_cnt = 1;
        hi_cnt  = 1;
      end else begin
        per_cnt++;
        if (clk_out) hi_cnt++;
      end
    end
    prev = clk_out;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_n(input logic [7:0] h, input logic [7:0] m, input logic [7:0] l);
    wr(2'd2, h); wr(2'd1, m); wr(2'd0, l);
  endtask

  task automatic wait_rises(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!rise_seen) @(negedge clk);
    end
  endtask

  task automatic expect_per(input int lo, input int hi, input string req, input bit grp, input int n);
    for (int i = 0; i < n; i++) q.push_back('{lo, hi, grp, req});
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    wait_rises(1);
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk(clk_out == 1'b0, "R1", clk_out, 0);
    end
    expect_per(50, 50, "R1", 0, 2);
    rst_n = 1;
    drain();

    set_n(8'h78, 8'h00, 8'h00);             // 30.0
    wait_rises(2);
    expect_per(30, 30, "R6", 0, 4);
    drain();

    set_n(8'h64, 8'h00, 8'h00);             // 25.0, odd period
    wait_rises(2);
    expect_per(25, 25, "R10", 0, 3);
    drain();

    wr(2'd2, 8'hA0); wr(2'd1, 8'h12);       // staged only
    wait_rises(2);
    expect_per(25, 25, "R3", 0, 3);
    drain();
    wr(2'd3, 8'h00);                        // unused address
    wait_rises(2);
    expect_per(25, 25, "R2", 0, 2);
    drain();
    wr(2'd0, 8'h00);                        // commits 40 + small fraction
    wait_rises(2);
    expect_per(40, 41, "R2", 0, 2);
    drain();

    expect_per(40, 41, "R9", 0, 1);
    wait_rises(1);
    repeat (5) @(negedge clk);
    set_n(8'h78, 8'h00, 8'h00);
    expect_per(30, 30, "R9", 0, 2);
    drain();

    set_n(8'h61, 8'hA8, 8'h00);             // 24.4140625
    wait_rises(2);
    grp_sum = 0;
    expect_per(24, 25, "R4", 1, 128);
    drain();
    chk(grp_sum == 3125, "R5", grp_sum, 3125);

    set_n(8'h28, 8'h55, 8'h55);             // integer 10
    wait_rises(2);
    expect_per(24, 24, "R7", 0, 3);
    drain();

    set_n(8'hC8, 8'hFF, 8'hFF);             // 50 + fraction
    wait_rises(2);
    expect_per(50, 50, "R8", 0, 3);
    drain();
    set_n(8'hF0, 8'h00, 8'h00);             // 60
    wait_rises(2);
    expect_per(50, 50, "R8", 0, 2);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    chk(1'b0, "watchdog", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule